// File: doc/BRIEF.md
# Conversion Phase Sequencer

This block sets the timing of the sampling phases for one analog-to-digital conversion. All of its timing is counted in conversion-clock ticks. A `qclk_en` enable pulse, derived from the system clock, marks each tick. A one-cycle `start` strobe begins a conversion. On that strobe the block captures a per-conversion setting: a two-bit sample-window select and a bypass flag. It then raises one phase flag at a time: initial sample, transfer, final sample and resolve. A single-cycle `done` pulse marks the end.

A normal conversion runs these phases in order:
- initial sample, 2 ticks;
- transfer, 4 ticks;
- final sample, with a length set by the select;
- resolve, a fixed 10 ticks.

A bypassed conversion goes straight to the final sample window. In that case the window is never shorter than 4 ticks. For checking, `total_cycles` gives the tick length of the conversion that is running. It is fixed when the conversion starts. The analog array, the successive-approximation logic and the queue of conversion commands are outside this block.

Top module: `conv_phase_seq`

## Requirements
- R1: After synchronous reset, all four phase flags and `done` are low and `total_cycles` is 0.
- R2: In a normal conversion, the final sample window lasts 2, 4, 8 or 16 ticks for select values 0, 1, 2 and 3 (window = 2 << select).
- R3: A normal conversion shows the initial sample flag for 2 ticks, then the transfer flag for 4 ticks, then final sample, then resolve. At most one phase flag is high at any time.
- R4: When the captured bypass flag is 1, the initial sample and transfer flags never rise. The conversion begins in the final sample phase.
- R5: In a bypassed conversion, the final window is the larger of 4 ticks and 2 << select. At select 0 this makes the conversion 4 ticks shorter than a normal one.
- R6: The resolve phase lasts 10 ticks. `done` is high for exactly one system clock cycle, the cycle right after the last resolve tick. The block is then idle.
- R7: Phases advance only on clock edges where `qclk_en` is 1. While `qclk_en` stays low, the active phase is held.
- R8: Select and bypass are captured on the accepted `start`. Later changes to these inputs have no effect on the conversion in progress. A `start` that arrives while a conversion is active is ignored.
- R9: `total_cycles` becomes (bypass ? 0 : 6) + final window + 10 on the edge that accepts `start`. It stays constant until the next accepted start or reset.
- R10: Each conversion uses its own settings. Back-to-back conversions with different select and bypass values each follow their own timing.
- R11: A synchronous reset during a conversion returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| qclk_en | input | 1 | Conversion-clock tick enable |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| samp_sel | input | SEL_W (2) | Final sample window select |
| byp | input | 1 | Bypass flag for this conversion |
| ph_init | output | 1 | Initial sample phase active |
| ph_xfer | output | 1 | Transfer phase active |
| ph_final | output | 1 | Final sample phase active |
| ph_resolve | output | 1 | Resolve phase active |
| done | output | 1 | One-cycle end-of-conversion pulse |
| total_cycles | output | CNT_W (6) | Tick length of the current conversion |

## Verification
The assertions check several properties on every cycle:
- at most one phase flag is high;
- a bypassed conversion never shows initial sample or transfer;
- the bypass window never drops below its floor;
- the phase and count are frozen without a tick;
- the captured settings and `total_cycles` stay stable while busy;
- `done` is a single cycle that follows resolve.

The exact tick count of each phase, the phase order, and the mapping from select to window are shown only by the bench scenarios. So are the 4-tick saving of bypass, the rejection of a start while busy, and correct timing across back-to-back conversions and a mid-conversion reset.

// File: rtl/conv_phase_pkg.sv
package conv_phase_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_INIT    = 3'd1,
      PH_XFER    = 3'd2,
      PH_FINAL   = 3'd3,
      PH_RESOLVE = 3'd4
   } phase_e;

   function automatic int max_total(input int init_t, input int xfer_t,
                                    input int base_t, input int sel_w,
                                    input int res_t, input int floor_t);
      int win;
      win = base_t << ((1 << sel_w) - 1);
      if (floor_t > win) win = floor_t;
      return init_t + xfer_t + win + res_t;
   endfunction

endpackage

// File: rtl/cps_cmd_latch.sv
module cps_cmd_latch #(
   parameter int SEL_W     = 2,
   parameter int CNT_W     = 6,
   parameter int BASE_T    = 2,
   parameter int BYP_MIN_T = 4,
   parameter int INIT_T    = 2,
   parameter int XFER_T    = 4,
   parameter int RES_T     = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             busy,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             byp_in,
   output logic             byp_q,
   output logic [CNT_W-1:0] final_nxt,
   output logic [CNT_W-1:0] final_len,
   output logic [CNT_W-1:0] total
);
   localparam int NSEL = 1 << SEL_W;
   localparam logic [CNT_W-1:0] FRONT_LEN = CNT_W'(INIT_T + XFER_T);
   localparam logic [CNT_W-1:0] RES_LEN   = CNT_W'(RES_T);
   localparam logic [CNT_W-1:0] FLOOR_LEN = CNT_W'(BYP_MIN_T);

   logic [CNT_W-1:0] win_tab [NSEL];
   logic [CNT_W-1:0] win_raw;
   logic [CNT_W-1:0] win_byp;
   logic [CNT_W-1:0] front_nxt;

   for (genvar g = 0; g < NSEL; g++) begin : g_win
      assign win_tab[g] = CNT_W'(BASE_T << g);
   end

   assign win_raw = win_tab[sel_in];

   if (BYP_MIN_T > 0) begin : g_floor
      assign win_byp = (win_raw < FLOOR_LEN) ? FLOOR_LEN : win_raw;
   end else begin : g_nofloor
      assign win_byp = win_raw;
   end

   assign final_nxt = byp_in ? win_byp : win_raw;
   assign front_nxt = byp_in ? '0 : FRONT_LEN;

   always_ff @(posedge clk) begin
      if (rst) begin
         byp_q     <= 1'b0;
         final_len <= '0;
         total     <= '0;
      end else if (accept) begin
         byp_q     <= byp_in;
         final_len <= final_nxt;
         total     <= front_nxt + final_nxt + RES_LEN;
      end
   end

   // R5: a bypassed conversion never runs a window below the floor
   assert_byp_floor_R5: assert property (@(posedge clk) disable iff (rst)
      (busy && byp_q) |-> (final_len >= FLOOR_LEN));

   // R8: captured settings hold while a conversion runs
   assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (busy && !accept) |=> ($stable(byp_q) && $stable(final_len) && $stable(total)));

endmodule

// File: rtl/cps_phase_fsm.sv
module cps_phase_fsm
   import conv_phase_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int INIT_T = 2,
   parameter int XFER_T = 4,
   parameter int RES_T  = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             start,
   input  logic             byp_in,
   input  logic [CNT_W-1:0] final_nxt,
   input  logic [CNT_W-1:0] final_len,
   output phase_e           phase,
   output logic             busy,
   output logic             accept,
   output logic             done
);
   localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_T - 1);
   localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFER_T - 1);
   localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_T - 1);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign busy   = (phase_q != PH_IDLE);
   assign accept = start && !busy;
   assign phase  = phase_q;
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (byp_in) begin
               phase_q <= PH_FINAL;
               cnt_q   <= final_nxt - ONE;
            end else begin
               phase_q <= PH_INIT;
               cnt_q   <= INIT_LAST;
            end
         end else if (busy && tick) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - ONE;
            end else begin
               unique case (phase_q)
                  PH_INIT: begin
                     phase_q <= PH_XFER;
                     cnt_q   <= XFER_LAST;
                  end
                  PH_XFER: begin
                     phase_q <= PH_FINAL;
                     cnt_q   <= final_len - ONE;
                  end
                  PH_FINAL: begin
                     phase_q <= PH_RESOLVE;
                     cnt_q   <= RES_LAST;
                  end
                  PH_RESOLVE: begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                     done_q  <= 1'b1;
                  end
                  default: begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                  end
               endcase
            end
         end
      end
   end

   // R7: no tick, no progress
   assert_tick_gate_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && !tick) |=> ($stable(phase_q) && $stable(cnt_q)));

   // R6: done lasts a single cycle
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R6: done only follows the resolve phase
   assert_done_after_resolve_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(phase_q) == PH_RESOLVE));

   // R4: a bypassed start lands directly in the final window
   assert_bypass_entry_R4: assert property (@(posedge clk) disable iff (rst)
      (accept && byp_in) |=> (phase_q == PH_FINAL));

endmodule

// File: rtl/cps_phase_out.sv
module cps_phase_out
   import conv_phase_pkg::*;
(
   input  phase_e phase,
   output logic   f_init,
   output logic   f_xfer,
   output logic   f_final,
   output logic   f_resolve
);
   always_comb begin
      f_init    = (phase == PH_INIT);
      f_xfer    = (phase == PH_XFER);
      f_final   = (phase == PH_FINAL);
      f_resolve = (phase == PH_RESOLVE);
   end
endmodule

// File: rtl/conv_phase_seq.sv
module conv_phase_seq
   import conv_phase_pkg::*;
#(
   parameter int SEL_W     = 2,
   parameter int BASE_T    = 2,
   parameter int BYP_MIN_T = 4,
   parameter int INIT_T    = 2,
   parameter int XFER_T    = 4,
   parameter int RES_T     = 10,
   localparam int CNT_W    = $clog2(max_total(INIT_T, XFER_T, BASE_T, SEL_W, RES_T, BYP_MIN_T) + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             qclk_en,
   input  logic             start,
   input  logic [SEL_W-1:0] samp_sel,
   input  logic             byp,
   output logic             ph_init,
   output logic             ph_xfer,
   output logic             ph_final,
   output logic             ph_resolve,
   output logic             done,
   output logic [CNT_W-1:0] total_cycles
);
   if (INIT_T < 1 || XFER_T < 1 || RES_T < 1 || BASE_T < 1) begin : g_bad_len
      $error("conv_phase_seq: every phase length must be at least one tick");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("conv_phase_seq: SEL_W out of supported range");
   end

   phase_e           phase;
   logic             busy;
   logic             accept;
   logic             byp_q;
   logic [CNT_W-1:0] final_nxt;
   logic [CNT_W-1:0] final_len;

   cps_cmd_latch #(
      .SEL_W(SEL_W), .CNT_W(CNT_W), .BASE_T(BASE_T), .BYP_MIN_T(BYP_MIN_T),
      .INIT_T(INIT_T), .XFER_T(XFER_T), .RES_T(RES_T)
   ) u_cmd (
      .clk(clk), .rst(rst), .accept(accept), .busy(busy),
      .sel_in(samp_sel), .byp_in(byp),
      .byp_q(byp_q), .final_nxt(final_nxt), .final_len(final_len),
      .total(total_cycles)
   );

   cps_phase_fsm #(
      .CNT_W(CNT_W), .INIT_T(INIT_T), .XFER_T(XFER_T), .RES_T(RES_T)
   ) u_fsm (
      .clk(clk), .rst(rst), .tick(qclk_en), .start(start), .byp_in(byp),
      .final_nxt(final_nxt), .final_len(final_len),
      .phase(phase), .busy(busy), .accept(accept), .done(done)
   );

   cps_phase_out u_out (
      .phase(phase), .f_init(ph_init), .f_xfer(ph_xfer),
      .f_final(ph_final), .f_resolve(ph_resolve)
   );

   // R3: never more than one phase flag
   assert_phase_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ph_init, ph_xfer, ph_final, ph_resolve}));

   // R4: a bypassed conversion shows no front phases
   assert_bypass_skip_R4: assert property (@(posedge clk) disable iff (rst)
      (byp_q && busy) |-> (!ph_init && !ph_xfer));

   // R9: the reported length holds while the conversion runs
   assert_total_stable_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(total_cycles));

endmodule

// File: tb/sim_conv_phase_seq.sv
module sim_conv_phase_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       qclk_en = 1'b0;
   logic       start = 1'b0;
   logic [1:0] samp_sel = 2'd0;
   logic       byp = 1'b0;
   logic       ph_init, ph_xfer, ph_final, ph_resolve, done;
   logic [5:0] total_cycles;

   int checks = 0;
   int errors = 0;

   int n_init, n_xfer, n_final, n_res, n_done, first_ph;
   bit order_bad, total_moved;
   int total_seen;

   always #5 clk = ~clk;

   conv_phase_seq u0 (
      .clk(clk), .rst(rst), .qclk_en(qclk_en), .start(start),
      .samp_sel(samp_sel), .byp(byp),
      .ph_init(ph_init), .ph_xfer(ph_xfer), .ph_final(ph_final),
      .ph_resolve(ph_resolve), .done(done), .total_cycles(total_cycles)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Runs one conversion; samples at negedge and counts ticks per phase.
   task automatic run_conv(input logic [1:0] s, input logic b, input int period, input bit inject);
      int idx, prev;
      @(negedge clk);
      samp_sel = s; byp = b; start = 1'b1; qclk_en = 1'b0;
      @(negedge clk);
      start = 1'b0; samp_sel = ~s; byp = ~b;
      n_init = 0; n_xfer = 0; n_final = 0; n_res = 0; n_done = 0;
      order_bad = 0; total_moved = 0; prev = 0; first_ph = -1;
      total_seen = int'(total_cycles);
      for (int cyc = 0; cyc < 5000; cyc++) begin
         idx = ph_init ? 1 : ph_xfer ? 2 : ph_final ? 3 : ph_resolve ? 4 : 0;
         if (done) n_done++;
         if (idx == 0 && !done && n_done > 0) break;
         if (int'(total_cycles) != total_seen) total_moved = 1;
         if (first_ph < 0) first_ph = idx;
         if (idx != 0 && idx < prev) order_bad = 1;
         if (idx != 0) prev = idx;
         qclk_en = ((cyc % period) == 0);
         if (inject && cyc == 3) begin
            start = 1'b1; samp_sel = 2'd3; byp = ~b;
         end else begin
            start = 1'b0;
         end
         if (qclk_en) begin
            case (idx)
               1: n_init++;
               2: n_xfer++;
               3: n_final++;
               4: n_res++;
               default: ;
            endcase
         end
         @(negedge clk);
      end
      qclk_en = 1'b0; start = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!ph_init && !ph_xfer && !ph_final && !ph_resolve, "R1 phases", {ph_init, ph_xfer, ph_final, ph_resolve}, 0);
      check(!done, "R1 done", done, 0);
      check(total_cycles == 0, "R1 total", total_cycles, 0);
   endtask

   task automatic t_normal_windows();
      for (int s = 0; s < 4; s++) begin
         run_conv(2'(s), 1'b0, 1, 1'b0);
         check(first_ph == 1, "R3 first phase", first_ph, 1);
         check(n_init == 2, "R3 init ticks", n_init, 2);
         check(n_xfer == 4, "R3 xfer ticks", n_xfer, 4);
         check(!order_bad, "R3 order", order_bad, 0);
         check(n_final == (2 << s), "R2 window", n_final, 2 << s);
         check(n_res == 10, "R6 resolve ticks", n_res, 10);
         check(n_done == 1, "R6 done width", n_done, 1);
         check(total_seen == 16 + (2 << s), "R9 total", total_seen, 16 + (2 << s));
         check(!total_moved, "R9 total stable", total_moved, 0);
      end
   endtask

   task automatic t_bypass();
      int win;
      for (int s = 0; s < 4; s++) begin
         win = (2 << s) < 4 ? 4 : (2 << s);
         run_conv(2'(s), 1'b1, 1, 1'b0);
         check(n_init == 0 && n_xfer == 0, "R4 skipped", n_init + n_xfer, 0);
         check(first_ph == 3, "R4 first phase", first_ph, 3);
         check(n_final == win, "R5 window", n_final, win);
         check(n_res == 10 && n_done == 1, "R6 bypass end", n_res * 10 + n_done, 101);
         check(total_seen == 10 + win, "R9 bypass total", total_seen, 10 + win);
      end
      check((16 + 2) - (10 + 4) == 4 && total_seen != 0, "R5 saving", 18 - 14, 4);
   endtask

   task automatic t_slow_tick();
      run_conv(2'd1, 1'b0, 3, 1'b0);
      check(n_init == 2 && n_xfer == 4, "R7 front ticks", n_init * 10 + n_xfer, 24);
      check(n_final == 4 && n_res == 10, "R7 back ticks", n_final * 100 + n_res, 410);
   endtask

   task automatic t_hold_and_reset();
      int held;
      held = 0;
      @(negedge clk);
      samp_sel = 2'd2; byp = 1'b0; start = 1'b1; qclk_en = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (ph_init) held++;
         @(negedge clk);
      end
      check(held == 20, "R7 held without tick", held, 20);
      check(total_cycles == 24, "R9 total at hold", total_cycles, 24);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!ph_init && !ph_xfer && !ph_final && !ph_resolve, "R11 idle after reset",
            {ph_init, ph_xfer, ph_final, ph_resolve}, 0);
      check(total_cycles == 0 && !done, "R11 cleared", total_cycles, 0);
   endtask

   task automatic t_busy_start();
      run_conv(2'd0, 1'b0, 1, 1'b1);
      check(n_init == 2 && n_xfer == 4, "R8 front kept", n_init * 10 + n_xfer, 24);
      check(n_final == 2, "R8 window kept", n_final, 2);
      check(total_seen == 18 && !total_moved, "R8 total kept", total_seen, 18);
   endtask

   task automatic t_back_to_back();
      run_conv(2'd3, 1'b0, 1, 1'b0);
      check(n_final == 16 && n_init == 2, "R10 first conv", n_final, 16);
      run_conv(2'd0, 1'b1, 1, 1'b0);
      check(n_final == 4 && n_init == 0, "R10 second conv", n_final, 4);
      check(total_seen == 14, "R10 second total", total_seen, 14);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_normal_windows();
      t_bypass();
      t_slow_tick();
      t_hold_and_reset();
      t_busy_start();
      t_back_to_back();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule